// File: doc/BRIEF.md
# Buck Switch Gate-Drive Sequencer

This block turns a PWM request into the two switch enables of a synchronous buck power stage. The stage switches once per converter cycle, and a strobe marks the start of each cycle. A fast clock times everything inside the cycle. The block drives the high-side switch while the request is high. It drives the low-side switch in the gaps, but only while the inductor current is large enough for synchronous operation. Both switches are held off for a fixed dead interval whenever the stage hands over from one switch to the other.

Comparator flags feed the block from outside. They report the sensed current against the synchronous threshold, the averaged current against the forced-asynchronous threshold, a low battery, a low bootstrap supply, overcurrent and battery overvoltage. From these flags the block does three things:

- It falls back to diode (discontinuous) operation when the current is low.
- It blocks the high side while a protection flag is raised.
- It inserts low-side refresh pulses that recharge the bootstrap capacitor. These pulses happen in two situations: during a long run at full duty, and during discontinuous operation.

Top module: `buck_gate_seq`

## Requirements
- R1: While `pwm_req` is high, `ovc` and `bat_ov` are low and no refresh pulse is active, `hs_en` is high. It follows a rising `pwm_req` on the next clock when the low side was already off long enough, and `hs_en` is low on the clock after any clock with `pwm_req` low.
- R2: In synchronous operation, `ls_en` is high whenever the high side is not requested. The high side counts as not requested when `pwm_req` is low or the high side is blocked by R10 or R11.
- R3: Between one switch turning off and the other turning on, both enables are low for exactly `DEAD_CYC` clocks.
- R4: Synchronous operation needs `sns_sync` high. Once `sns_sync` is low on any clock of a cycle, `ls_en` stays low (except for refresh pulses) until the next `cyc_start`, even if `sns_sync` returns.
- R5: `avg_low` high or `vbat_low` high forces non-synchronous operation with the same rule as R4.
- R6: Count each `cyc_start` at which `boot_low` is high and `pwm_req` was high through the whole cycle just ended. The count is of consecutive such strobes. On the (`BOOT_LIM`+1)-th, the high side drops and the low side is driven for exactly `REFRESH_CYC` clocks. Full duty then resumes.
- R7: A `cyc_start` with `boot_low` low, or with a cycle that was not full duty, clears the consecutive count of R6.
- R8: In non-synchronous operation with `pwm_req` low, a high `boot_low` produces one low-side pulse of exactly `REFRESH_CYC` clocks per cycle. The low side then stays off until the next `cyc_start`.
- R9: With `pwm_req` low for whole cycles, `hs_en` never rises.
- R10: `bat_ov` high forces `hs_en` low on the next clock.
- R11: `ovc` high forces `hs_en` low on the next clock. The high side resumes by itself once `ovc` falls.
- R12: After reset both enables are low, and `hs_en` and `ls_en` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| pwm_req | input | 1 | High-side on request from the PWM comparator |
| sns_sync | input | 1 | Sensed current above the synchronous threshold |
| avg_low | input | 1 | Averaged current below the forced-asynchronous threshold |
| vbat_low | input | 1 | Battery below the low-voltage limit |
| boot_low | input | 1 | Bootstrap supply below its refresh threshold |
| ovc | input | 1 | Charge current above the overcurrent limit |
| bat_ov | input | 1 | Battery at or above the overvoltage limit |
| hs_en | output | 1 | High-side switch enable, registered |
| ls_en | output | 1 | Low-side switch enable, registered |

## Verification
The hardest state to reach is the full-duty bootstrap refresh. It appears only after several consecutive strobes, each closing a cycle in which the request never dropped, with the bootstrap flag high at every one of them. One strobe with the flag clear must silently restart the count. The stimulus holds `pwm_req` high in non-synchronous mode, so that no low-side activity hides the pulse. It steps exactly `BOOT_LIM` qualifying strobes and confirms that no low-side clock appears. The next strobe must then yield exactly `REFRESH_CYC` low-side clocks. The clearing run inserts a strobe with the flag low in the middle of the sequence and shows that the pulse comes only after a full fresh count.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  // Per-clock request for the two switches before dead-time gating.
  typedef struct packed {
    logic hs;
    logic ls;
  } gate_req_t;

endpackage

// File: rtl/bgs_mode_sel.sv
module bgs_mode_sel (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic sns_sync,
  input  logic avg_low,
  input  logic vbat_low,
  output logic sync_eff
);

  logic sync_now;
  logic sync_q;

  // Synchronous only with enough current and no forcing condition.
  assign sync_now = sns_sync & ~avg_low & ~vbat_low;
  // Once lost inside a cycle, it is regained only at the next strobe.
  assign sync_eff = cyc_start ? sync_now : (sync_q & sync_now);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= sync_eff;
  end

endmodule

// File: rtl/bgs_boot_refresh.sv
module bgs_boot_refresh #(
  parameter int BOOT_LIM    = 3,
  parameter int REFRESH_CYC = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic pwm_req,
  input  logic boot_low,
  input  logic sync_eff,
  input  logic ls_q,
  output logic rf_act,
  output logic rf_done
);

  localparam int LW = $clog2(BOOT_LIM + 1);
  localparam int RW = (REFRESH_CYC > 1) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [LW-1:0] LIM_V   = LW'(BOOT_LIM);
  localparam logic [RW-1:0] RF_LAST = RW'(REFRESH_CYC - 1);

  logic          full_q;
  logic [LW-1:0] low_cnt;
  logic          used_q;
  logic [RW-1:0] rf_cnt;
  logic          qual, trig_fd, trig_dcm, used_eff;

  always_comb begin
    qual     = cyc_start & boot_low & full_q & pwm_req;
    trig_fd  = qual & (low_cnt == LIM_V);
    used_eff = used_q & ~cyc_start;
    trig_dcm = ~sync_eff & boot_low & ~pwm_req & ~used_eff & ~rf_act;
    rf_done  = rf_act & ls_q & (rf_cnt == RF_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      low_cnt <= '0;
      used_q  <= 1'b0;
      rf_act  <= 1'b0;
      rf_cnt  <= '0;
    end else begin
      full_q <= cyc_start ? pwm_req : (full_q & pwm_req);
      if (cyc_start)
        low_cnt <= qual ? (trig_fd ? '0 : low_cnt + 1'b1) : '0;
      used_q <= trig_dcm | used_eff;
      if (rf_act) rf_act <= ~rf_done;
      else        rf_act <= trig_fd | trig_dcm;
      if (!rf_act)  rf_cnt <= '0;
      else if (ls_q) rf_cnt <= rf_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bgs_dead_time.sv
module bgs_dead_time
  import buck_seq_pkg::*;
#(
  parameter int DEAD_CYC = 30
) (
  input  logic      clk,
  input  logic      rst,
  input  gate_req_t want,
  output logic      hs_q,
  output logic      ls_q
);

  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

  logic [DW-1:0] idle_cnt;
  logic          idle_ok, hs_d, ls_d;

  always_comb begin
    idle_ok = (idle_cnt >= DEAD_V);
    hs_d    = want.hs & (hs_q | (~ls_q & idle_ok));
    ls_d    = want.ls & (ls_q | (~hs_q & idle_ok));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q     <= 1'b0;
      ls_q     <= 1'b0;
      idle_cnt <= DEAD_V;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
      if (hs_d | ls_d)  idle_cnt <= '0;
      else if (!idle_ok) idle_cnt <= idle_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import buck_seq_pkg::*;
#(
  parameter int DEAD_CYC    = 30,
  parameter int REFRESH_CYC = 80,
  parameter int BOOT_LIM    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic pwm_req,
  input  logic sns_sync,
  input  logic avg_low,
  input  logic vbat_low,
  input  logic boot_low,
  input  logic ovc,
  input  logic bat_ov,
  output logic hs_en,
  output logic ls_en
);

  logic      sync_eff, rf_act, rf_done;
  gate_req_t want;

  bgs_mode_sel mode_i (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .sns_sync(sns_sync),
    .avg_low(avg_low), .vbat_low(vbat_low), .sync_eff(sync_eff)
  );

  bgs_boot_refresh #(.BOOT_LIM(BOOT_LIM), .REFRESH_CYC(REFRESH_CYC)) refresh_i (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .pwm_req(pwm_req),
    .boot_low(boot_low), .sync_eff(sync_eff), .ls_q(ls_en),
    .rf_act(rf_act), .rf_done(rf_done)
  );

  always_comb begin
    want.hs = pwm_req & ~ovc & ~bat_ov & ~rf_act;
    want.ls = rf_act ? ~rf_done : (sync_eff & ~want.hs);
  end

  bgs_dead_time #(.DEAD_CYC(DEAD_CYC)) dead_i (
    .clk(clk), .rst(rst), .want(want), .hs_q(hs_en), .ls_q(ls_en)
  );

endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
  parameter int DEAD_CYC = 30
) (
  input logic clk,
  input logic rst,
  input logic pwm_req,
  input logic ovc,
  input logic bat_ov,
  input logic hs_en,
  input logic ls_en
);

  int idle_c;

  always_ff @(posedge clk) begin
    if (rst)                 idle_c <= DEAD_CYC;
    else if (hs_en || ls_en) idle_c <= 0;
    else if (idle_c < DEAD_CYC) idle_c <= idle_c + 1;
  end

  a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  a_r3_dead_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_en) || $rose(ls_en)) |-> (idle_c >= DEAD_CYC));

  a_r10_ov_block: assert property (@(posedge clk) disable iff (rst)
    bat_ov |=> !hs_en);

  a_r11_oc_block: assert property (@(posedge clk) disable iff (rst)
    ovc |=> !hs_en);

  a_r1_no_req_off: assert property (@(posedge clk) disable iff (rst)
    !pwm_req |=> !hs_en);

endmodule

bind buck_gate_seq bgs_checker #(.DEAD_CYC(DEAD_CYC)) chk_i (
  .clk(clk), .rst(rst), .pwm_req(pwm_req), .ovc(ovc), .bat_ov(bat_ov),
  .hs_en(hs_en), .ls_en(ls_en)
);

// File: tb/buck_gate_seq_tb_top.sv
`timescale 1ns/1ps
module buck_gate_seq_tb_top;

  localparam int DEAD = 4;
  localparam int RF   = 6;
  localparam int LIM  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 0, pwm_req = 0, sns_sync = 0, avg_low = 0;
  logic vbat_low = 0, boot_low = 0, ovc = 0, bat_ov = 0;
  logic hs_en, ls_en;

  int tests = 0, fails = 0;
  int ls_hi = 0, hs_hi = 0, ov_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  buck_gate_seq #(.DEAD_CYC(DEAD), .REFRESH_CYC(RF), .BOOT_LIM(LIM)) dut_i (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .pwm_req(pwm_req),
    .sns_sync(sns_sync), .avg_low(avg_low), .vbat_low(vbat_low),
    .boot_low(boot_low), .ovc(ovc), .bat_ov(bat_ov),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  always @(negedge clk) if (!rst) begin
    if (ls_en) ls_hi++;
    if (hs_en) hs_hi++;
    if (hs_en && ls_en) ov_err++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    cyc_start = 1; step(1); cyc_start = 0;
  endtask

  task automatic count_off(output int n);
    n = 0;
    while (!hs_en && !ls_en && n < 100) begin n++; step(1); end
  endtask

  task automatic t_reset();
    chk(!hs_en && !ls_en, "R12 reset", {hs_en, ls_en}, 0);
  endtask

  task automatic t_sync_dead();
    int n;
    sns_sync = 1; pwm_req = 0; pulse_start();
    chk(ls_en && !hs_en, "R2 complementary low side", {hs_en, ls_en}, 1);
    pwm_req = 1; step(1); count_off(n);
    chk(n == DEAD, "R3 gap ls->hs", n, DEAD);
    chk(hs_en == 1, "R1 high side follows request", hs_en, 1);
    pwm_req = 0; step(1); count_off(n);
    chk(n == DEAD, "R3 gap hs->ls", n, DEAD);
    chk(ls_en == 1, "R2 low side after gap", ls_en, 1);
  endtask

  task automatic t_protect();
    pwm_req = 1; step(DEAD + 2);
    chk(hs_en == 1, "R1 on before protection", hs_en, 1);
    bat_ov = 1; step(1);
    chk(hs_en == 0, "R10 overvoltage blocks", hs_en, 0);
    step(DEAD + 2);
    chk(ls_en == 1 && hs_en == 0, "R10 blocked cycle complementary", ls_en, 1);
    bat_ov = 0; step(DEAD + 2);
    chk(hs_en == 1, "R10 released", hs_en, 1);
    ovc = 1; step(1);
    chk(hs_en == 0, "R11 overcurrent blocks", hs_en, 0);
    step(3);
    chk(hs_en == 0, "R11 stays blocked", hs_en, 0);
    ovc = 0; step(DEAD + 2);
    chk(hs_en == 1, "R11 auto resume", hs_en, 1);
    pwm_req = 0; step(DEAD + 2);
  endtask

  task automatic t_async_latch();
    chk(ls_en == 1, "R4 start in sync", ls_en, 1);
    sns_sync = 0; step(1);
    chk(ls_en == 0, "R4 low side off below threshold", ls_en, 0);
    sns_sync = 1; step(8);
    chk(ls_en == 0, "R4 off for rest of cycle", ls_en, 0);
    pulse_start();
    chk(ls_en == 1, "R4 back at next cycle", ls_en, 1);
  endtask

  task automatic t_forced();
    avg_low = 1; step(1);
    chk(ls_en == 0, "R5 averaged low forces async", ls_en, 0);
    avg_low = 0; step(4);
    chk(ls_en == 0, "R5 held until strobe", ls_en, 0);
    pulse_start();
    chk(ls_en == 1, "R5 resumes", ls_en, 1);
    vbat_low = 1; step(1);
    chk(ls_en == 0, "R5 low battery forces async", ls_en, 0);
    pulse_start();
    chk(ls_en == 0, "R5 strobe during low battery", ls_en, 0);
    vbat_low = 0; step(3);
    pulse_start();
    chk(ls_en == 1, "R5 resumes after battery", ls_en, 1);
  endtask

  task automatic t_full_refresh();
    int base;
    sns_sync = 0; boot_low = 0; pwm_req = 1; step(DEAD + 2);
    pulse_start(); step(9);
    boot_low = 1; base = ls_hi;
    for (int i = 0; i < LIM; i++) begin pulse_start(); step(9); end
    chk(ls_hi == base, "R6 no refresh before limit", ls_hi - base, 0);
    pulse_start(); step(40);
    chk(ls_hi - base == RF, "R6 refresh width", ls_hi - base, RF);
    chk(hs_en == 1, "R6 full duty resumes", hs_en, 1);
  endtask

  task automatic t_count_clear();
    int base = ls_hi;
    pulse_start(); step(9);
    pulse_start(); step(9);
    boot_low = 0; pulse_start(); step(9);
    boot_low = 1;
    for (int i = 0; i < LIM; i++) begin pulse_start(); step(9); end
    chk(ls_hi == base, "R7 count cleared", ls_hi - base, 0);
    pulse_start(); step(40);
    chk(ls_hi - base == RF, "R7 refresh after fresh count", ls_hi - base, RF);
    boot_low = 0;
  endtask

  task automatic t_dcm_refresh();
    int lb, hb;
    pwm_req = 0; sns_sync = 0; step(DEAD + 2);
    pulse_start();
    lb = ls_hi; hb = hs_hi;
    boot_low = 1; step(30);
    chk(ls_hi - lb == RF, "R8 one pulse per cycle", ls_hi - lb, RF);
    pulse_start(); step(30);
    chk(ls_hi - lb == 2 * RF, "R8 pulse in next cycle", ls_hi - lb, 2 * RF);
    chk(hs_hi == hb, "R9 zero duty keeps high side off", hs_hi - hb, 0);
    boot_low = 0;
  endtask

  initial begin
    step(4); rst = 0; step(1);
    t_reset();
    t_sync_dead();
    t_protect();
    t_async_latch();
    t_forced();
    t_full_refresh();
    t_count_clear();
    t_dcm_refresh();
    chk(ov_err == 0, "R12 never both on", ov_err, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule